// File: doc/BRIEF.md
# Two-Stage Segment and Page Address Translator

This block turns a 16-bit virtual address into a 16-bit real address. The virtual address carries three fields. The top four bits select a segment, the next four bits select a page within that segment, and the low eight bits are a byte displacement. The segment table gives a page-table base for the chosen segment. The block adds the page field to that base, modulo the page-table depth, which gives a page-table slot. That slot holds a residency flag and a frame number. The real address is the frame number placed above the displacement, and the displacement passes through unchanged.

Both tables live in register arrays inside the block, and a host write port loads them. A four-entry fully associative lookup buffer sits in front of each table. One buffer keeps segment-to-base pairs. The other keeps slot-to-frame pairs, and only for resident pages. Each buffer replaces entries in round-robin order.

Requests use a valid/ready handshake. The block answers each request with a one-cycle response pulse. The pulse carries either the real address or a fault flag. A flush input empties both buffers in one cycle.

Top module: `seg_page_xlat`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid` is 0, and every table entry reads as zero. A translation before any table write therefore faults.
- R2: For a resident page, `resp_addr` equals {frame, `req_vaddr[7:0]`}. The segment field is `req_vaddr[15:12]` and the page field is `req_vaddr[11:8]`.
- R3: The page-table slot is (segment base + page field) modulo 64, so the sum wraps at 64.
- R4: A slot whose bit 8 (the valid bit) is 0 gives a response with `resp_fault` = 1 and `resp_addr` = 0.
- R5: When both buffers hit, `resp_valid` rises in the cycle right after the request is accepted.
- R6: Each buffer miss adds exactly one cycle to the response. `req_ready` stays 0 from the accepting edge until the edge that raises `resp_valid`.
- R7: Each buffer fills on a miss. It writes the entry selected by its round-robin pointer, which advances by one on every fill and wraps after entry 3.
- R8: A host write invalidates every buffer entry tagged with the written index. The host port uses `host_sel` = 0 for the segment table (base in `host_data[5:0]`, index in `host_idx[3:0]`) and `host_sel` = 1 for the page table (valid in `host_data[8]`, frame in `host_data[7:0]`, slot in `host_idx`). The next translation therefore returns the new contents.
- R9: A `flush` pulse invalidates every entry in both buffers.
- R10: A faulting page-table read does not fill the page buffer. Repeating the same request misses in the page buffer again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 16 | Virtual address {segment, page, displacement} |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_fault | output | 1 | Page not resident |
| resp_addr | output | 16 | Real address {frame, displacement}, 0 on fault |
| host_we | input | 1 | Table write strobe |
| host_sel | input | 1 | 0 selects the segment table, 1 the page table |
| host_idx | input | 6 | Entry index to write |
| host_data | input | 9 | Entry contents |
| flush | input | 1 | Invalidate both lookup buffers |

## Verification
Each response is due 1, 2 or 3 cycles after the accepting edge. The delay is one cycle plus one cycle for each buffer miss. The bench's behavioural model keeps its own copy of the tables, the buffer tags and the round-robin pointers, and predicts that delay before it drives each request. The bench then samples at every falling edge up to the predicted cycle. It expects `resp_valid` low and `req_ready` low before that cycle, and at that cycle it expects the pulse together with the predicted address or fault. A wrong latency, a wrong replacement order or a stale buffer entry therefore shows up as a mismatch in a specific cycle.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEG  = 2'd1,
        ST_PAGE = 2'd2
    } xlat_st_e;
endpackage

// File: rtl/xlat_table.sv
module xlat_table #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0][DATA_W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (wr_en) mem_d[wr_addr] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/xlat_lookbuf.sv
module xlat_lookbuf #(
    parameter int TAG_W   = 4,
    parameter int DATA_W  = 6,
    parameter int ENTRIES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              hit,
    output logic [DATA_W-1:0] hit_data,
    input  logic              fill_en,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              inv_en,
    input  logic [TAG_W-1:0]  inv_tag,
    input  logic              flush
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic [ENTRIES-1:0]             vld;
        logic [ENTRIES-1:0][TAG_W-1:0]  tag;
        logic [ENTRIES-1:0][DATA_W-1:0] dat;
        logic [PTR_W-1:0]               ptr;
    } lb_t;

    lb_t lb_d, lb_q;
    logic [ENTRIES-1:0] match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = lb_q.vld[g] && (lb_q.tag[g] == lk_tag);
    end

    always_comb begin
        hit_data = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) hit_data = hit_data | lb_q.dat[i];
        end
    end
    assign hit = |match;

    always_comb begin
        lb_d = lb_q;
        if (flush) begin
            lb_d.vld = '0;
        end else begin
            if (inv_en) begin
                for (int i = 0; i < ENTRIES; i++) begin
                    if (lb_q.tag[i] == inv_tag) lb_d.vld[i] = 1'b0;
                end
            end
            if (fill_en && !(inv_en && inv_tag == fill_tag)) begin
                lb_d.vld[lb_q.ptr] = 1'b1;
                lb_d.tag[lb_q.ptr] = fill_tag;
                lb_d.dat[lb_q.ptr] = fill_data;
                lb_d.ptr = (lb_q.ptr == PTR_W'(ENTRIES-1)) ? '0 : lb_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lb_q <= '0;
        else        lb_q <= lb_d;
    end

    AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match)) else $error("duplicate tag in lookup buffer"); // R7

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !hit) else $error("hit right after flush"); // R9
endmodule

// File: rtl/seg_page_xlat.sv
module seg_page_xlat #(
    parameter int SEG_W   = 4,
    parameter int PG_W    = 4,
    parameter int DISP_W  = 8,
    parameter int PT_AW   = 6,
    parameter int FRAME_W = 8,
    parameter int BUF_N   = 4,
    localparam int VA_W   = SEG_W + PG_W + DISP_W,
    localparam int RA_W   = FRAME_W + DISP_W,
    localparam int HI_W   = (PT_AW > SEG_W) ? PT_AW : SEG_W,
    localparam int PE_W   = FRAME_W + 1,
    localparam int HD_W   = (PT_AW > PE_W) ? PT_AW : PE_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_vaddr,
    output logic            resp_valid,
    output logic            resp_fault,
    output logic [RA_W-1:0] resp_addr,
    input  logic            host_we,
    input  logic            host_sel,
    input  logic [HI_W-1:0] host_idx,
    input  logic [HD_W-1:0] host_data,
    input  logic            flush
);
    import xlat_pkg::*;

    typedef struct packed {
        xlat_st_e         st;
        logic [VA_W-1:0]  va;
        logic [PT_AW-1:0] pta;
        logic             rvld;
        logic             rflt;
        logic [RA_W-1:0]  raddr;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [VA_W-1:0]   cur_va;
    logic [SEG_W-1:0]  seg_f;
    logic [PG_W-1:0]   pg_f;
    logic [DISP_W-1:0] disp_f;
    logic              sb_hit, pb_hit;
    logic [PT_AW-1:0]  sb_base, st_base, base_sel, pt_slot;
    logic [FRAME_W-1:0] pb_frame;
    logic [PE_W-1:0]   pt_entry;
    logic [PT_AW-1:0]  pb_lk;
    logic              sb_fill, pb_fill;

    assign cur_va = (c_q.st == ST_IDLE) ? req_vaddr : c_q.va;
    assign seg_f  = cur_va[VA_W-1 -: SEG_W];
    assign pg_f   = cur_va[DISP_W +: PG_W];
    assign disp_f = cur_va[DISP_W-1:0];

    xlat_table #(.ADDR_W(SEG_W), .DATA_W(PT_AW)) u_seg_tab (
        .clk(clk), .rst_n(rst_n),
        .wr_en(host_we && !host_sel), .wr_addr(host_idx[SEG_W-1:0]),
        .wr_data(host_data[PT_AW-1:0]),
        .rd_addr(seg_f), .rd_data(st_base)
    );

    xlat_table #(.ADDR_W(PT_AW), .DATA_W(PE_W)) u_pg_tab (
        .clk(clk), .rst_n(rst_n),
        .wr_en(host_we && host_sel), .wr_addr(host_idx[PT_AW-1:0]),
        .wr_data(host_data[PE_W-1:0]),
        .rd_addr(c_q.pta), .rd_data(pt_entry)
    );

    assign base_sel = (c_q.st == ST_IDLE) ? sb_base : st_base;
    assign pt_slot  = base_sel + PT_AW'(pg_f);
    assign pb_lk    = (c_q.st == ST_PAGE) ? c_q.pta : pt_slot;

    xlat_lookbuf #(.TAG_W(SEG_W), .DATA_W(PT_AW), .ENTRIES(BUF_N)) u_seg_buf (
        .clk(clk), .rst_n(rst_n),
        .lk_tag(seg_f), .hit(sb_hit), .hit_data(sb_base),
        .fill_en(sb_fill), .fill_tag(seg_f), .fill_data(st_base),
        .inv_en(host_we && !host_sel), .inv_tag(host_idx[SEG_W-1:0]),
        .flush(flush)
    );

    xlat_lookbuf #(.TAG_W(PT_AW), .DATA_W(FRAME_W), .ENTRIES(BUF_N)) u_pg_buf (
        .clk(clk), .rst_n(rst_n),
        .lk_tag(pb_lk), .hit(pb_hit), .hit_data(pb_frame),
        .fill_en(pb_fill), .fill_tag(c_q.pta), .fill_data(pt_entry[FRAME_W-1:0]),
        .inv_en(host_we && host_sel), .inv_tag(host_idx[PT_AW-1:0]),
        .flush(flush)
    );

    always_comb begin
        c_d      = c_q;
        c_d.rvld = 1'b0;
        c_d.rflt = 1'b0;
        sb_fill  = 1'b0;
        pb_fill  = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    c_d.va  = req_vaddr;
                    c_d.pta = pt_slot;
                    if (!sb_hit) begin
                        c_d.st = ST_SEG;
                    end else if (!pb_hit) begin
                        c_d.st = ST_PAGE;
                    end else begin
                        c_d.rvld  = 1'b1;
                        c_d.raddr = {pb_frame, disp_f};
                    end
                end
            end
            ST_SEG: begin
                sb_fill = 1'b1;
                c_d.pta = pt_slot;
                if (pb_hit) begin
                    c_d.st    = ST_IDLE;
                    c_d.rvld  = 1'b1;
                    c_d.raddr = {pb_frame, disp_f};
                end else begin
                    c_d.st = ST_PAGE;
                end
            end
            ST_PAGE: begin
                c_d.st   = ST_IDLE;
                c_d.rvld = 1'b1;
                if (pt_entry[FRAME_W]) begin
                    pb_fill   = 1'b1;
                    c_d.raddr = {pt_entry[FRAME_W-1:0], disp_f};
                end else begin
                    c_d.rflt  = 1'b1;
                    c_d.raddr = '0;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign req_ready  = (c_q.st == ST_IDLE);
    assign resp_valid = c_q.rvld;
    assign resp_fault = c_q.rflt;
    assign resp_addr  = c_q.raddr;

    AST_ACCEPT_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (resp_valid || !req_ready))
        else $error("accepted request neither answered nor stalled"); // R5

    AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault) |-> (resp_addr == '0))
        else $error("fault with nonzero address"); // R4

    AST_PAGE_READ_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_PAGE) |=> (resp_valid && req_ready))
        else $error("page-table read did not answer"); // R6

    AST_BUSY_NO_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> !resp_valid)
        else $error("response while still busy"); // R6
endmodule

// File: tb/seg_page_xlat_tb.sv
module seg_page_xlat_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_vaddr = '0;
    logic        resp_valid, resp_fault;
    logic [15:0] resp_addr;
    logic        host_we = 1'b0, host_sel = 1'b0;
    logic [5:0]  host_idx = '0;
    logic [8:0]  host_data = '0;
    logic        flush = 1'b0;

    int checks = 0;
    int errors = 0;

    int seg_tab [16];
    int pg_val  [64];
    int pg_frm  [64];
    int s_tag [4]; bit s_v [4]; int s_ptr = 0;
    int p_tag [4]; bit p_v [4]; int p_ptr = 0;

    always #2.5 clk = ~clk;

    seg_page_xlat u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .resp_valid(resp_valid), .resp_fault(resp_fault),
        .resp_addr(resp_addr), .host_we(host_we), .host_sel(host_sel),
        .host_idx(host_idx), .host_data(host_data), .flush(flush)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic bit buf_has(input bit seg, input int t);
        for (int i = 0; i < 4; i++) begin
            if (seg && s_v[i] && s_tag[i] == t) return 1'b1;
            if (!seg && p_v[i] && p_tag[i] == t) return 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic do_xlat(input logic [15:0] va, input string tag);
        int s, pi, d, pa, lat;
        bit efault;
        int eaddr;
        s = va[15:12]; pi = va[11:8]; d = va[7:0];
        lat = 1;
        if (!buf_has(1'b1, s)) begin
            lat++;
            s_tag[s_ptr] = s; s_v[s_ptr] = 1'b1; s_ptr = (s_ptr + 1) % 4;
        end
        pa = (seg_tab[s] + pi) % 64;
        if (!buf_has(1'b0, pa)) begin
            lat++;
            if (pg_val[pa] != 0) begin
                p_tag[p_ptr] = pa; p_v[p_ptr] = 1'b1; p_ptr = (p_ptr + 1) % 4;
            end
        end
        efault = (pg_val[pa] == 0);
        eaddr  = efault ? 0 : ((pg_frm[pa] << 8) | d);
        @(negedge clk);
        chk(req_ready == 1'b1, tag, "ready before request", req_ready, 1);
        req_valid = 1'b1;
        req_vaddr = va;
        for (int k = 1; k <= lat; k++) begin
            @(negedge clk);
            if (k == 1) req_valid = 1'b0;
            chk(resp_valid == (k == lat), tag, "resp_valid timing", resp_valid, (k == lat));
            if (k < lat) chk(req_ready == 1'b0, "R6", "ready while busy", req_ready, 0);
            if (k == lat) begin
                chk(resp_fault == efault, tag, "fault", resp_fault, efault);
                chk(resp_addr == 16'(eaddr), tag, "real address", resp_addr, eaddr);
            end
        end
    endtask

    task automatic hwrite(input bit sel, input int idx, input int data);
        @(negedge clk);
        host_we = 1'b1; host_sel = sel; host_idx = 6'(idx); host_data = 9'(data);
        @(negedge clk);
        host_we = 1'b0;
        if (!sel) begin
            seg_tab[idx % 16] = data % 64;
            for (int i = 0; i < 4; i++) if (s_tag[i] == idx % 16) s_v[i] = 1'b0;
        end else begin
            pg_val[idx] = (data >> 8) & 1;
            pg_frm[idx] = data & 255;
            for (int i = 0; i < 4; i++) if (p_tag[i] == idx) p_v[i] = 1'b0;
        end
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        for (int i = 0; i < 4; i++) begin s_v[i] = 1'b0; p_v[i] = 1'b0; end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) seg_tab[i] = 0;
        for (int i = 0; i < 64; i++) begin pg_val[i] = 0; pg_frm[i] = 0; end
        for (int i = 0; i < 4; i++) begin s_v[i] = 0; p_v[i] = 0; s_tag[i] = 0; p_tag[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        chk(resp_valid == 1'b0, "R1", "no response after reset", resp_valid, 0);
        do_xlat(16'h0123, "R1");

        hwrite(0, 0, 10);  hwrite(0, 1, 60);
        hwrite(0, 2, 20);  hwrite(0, 3, 30);
        hwrite(0, 4, 40);  hwrite(0, 5, 50);
        hwrite(1, 12, 9'h1A7); hwrite(1, 2, 9'h133);
        hwrite(1, 21, 9'h151); hwrite(1, 31, 9'h161);
        hwrite(1, 41, 9'h171); hwrite(1, 51, 9'h181);

        do_xlat(16'h025A, "R2");
        do_xlat(16'h02C3, "R5");
        do_xlat(16'h16FF, "R3");
        do_xlat(16'h2101, "R6");
        do_xlat(16'h3102, "R7");
        do_xlat(16'h4103, "R7");
        do_xlat(16'h5104, "R7");
        do_xlat(16'h0211, "R7");
        do_xlat(16'h0522, "R4");
        do_xlat(16'h0533, "R10");
        do_xlat(16'h0244, "R5");
        hwrite(1, 12, 9'h13C);
        do_xlat(16'h0255, "R8");
        hwrite(0, 0, 2);
        do_xlat(16'h0066, "R8");
        do_xlat(16'h0077, "R5");
        do_flush();
        do_xlat(16'h0088, "R9");
        do_xlat(16'h16AA, "R9");
        do_xlat(16'h16BB, "R5");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule